// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is a timer/counter with four compare channels and a word-wide register bus. In timer mode, a free-running divider turns a reference strobe into counting steps. The strobe pulses at 16 MHz in the target system. The divider ratio is a power of two set by a prescale field. In counter mode, the count moves only when software issues an explicit increment task. The count width is selected at run time from four widths, and the count wraps at the top of the selected width.

Each channel holds a compare value. When the count steps onto a channel's compare value, that channel raises a flag. The flag stays up until software writes zero to it. A match can also trigger two per-channel shortcuts: one sends the count back to zero, and the other halts counting. Capture tasks copy the live count into a channel's compare register; software reads the count this way. One interrupt line combines the flags through an enable mask. The mask has separate set and clear registers.

Register reads return data one cycle after the request, and `bus_rvalid` marks that data. All addresses below are word indices on `bus_addr`.

Top module: `ct_timer`

## Requirements
- R1: After reset, the count, all compare values, all flags, the enable mask, the shortcut register, the prescale field and the error bit read zero, and `irq` is low.
- R2: The width field (index 28) maps code 0 to 16 bits, code 1 to 8 bits, code 2 to 24 bits and code 3 to 32 bits. The count wraps to zero after the largest value of the selected width.
- R3: A value written to a compare register (indices 32+i) is stored reduced modulo 2^width.
- R4: In timer mode (mode index 27, value 0), a running count advances once per 2^p reference strobes, where p is the prescale field (index 29). A write above 9 stores 9.
- R5: In counter mode (mode value 1), writing 1 to the increment task (index 2) adds one to the count. The start task (index 0) has no effect in counter mode, and the increment task has no effect in timer mode.
- R6: The stop task (index 1) and the shutdown task (index 4) both halt counting without changing the count. The clear task (index 3) sets the count to zero.
- R7: Writing 1 to capture task i (index 8+i) copies the current count into compare register i.
- R8: When the count steps onto compare value i, flag i (index 16+i, bit 0) becomes 1. It stays 1 until a write of zero to that index; a nonzero write leaves it unchanged.
- R9: When shortcut bit i (index 24, bit i) is set, a channel-i match sends the count to zero instead of to the compare value.
- R10: When shortcut bit 8+i is set, a channel-i match halts counting, and the count keeps the matched value.
- R11: `irq` is high, one cycle after the cause, when some flag i is 1 while enable bit 16+i is set. Writing index 25 sets enable bits, writing index 26 clears them, and reading either index returns the mask.
- R12: Task indices act only when the written value is exactly 1. Any other value has no effect.
- R13: A read of an unmapped index returns zero, a write to one changes nothing, and every read request gets `bus_rvalid` on the next cycle.
- R14: A write to the width or prescale field while timer mode is counting is still applied. It also sets a sticky error bit (index 30, bit 0), which a write of 1 to that index clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference strobe that feeds the prescale divider |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | AW | Word index of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: four channels, a 32-bit data path, a 6-bit index and a prescale limit of 9. It holds `ref_tick` high, so timer-mode runs have exact step counts. A 16-bit wrap is then reachable in about 65 thousand cycles, and an 8-bit wrap takes 256 increment tasks. The 24-bit and 32-bit codes are checked through the masking of compare writes. With four channels, the bench can run a clear shortcut on one channel and a stop shortcut on another, while the other channels hold compare values the count never reaches.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int NUM_CH    = 4;
  localparam int PRESC_W   = 4;
  localparam int PRESC_MAX = 9;

  // word indices of the register map
  localparam int A_START   = 0;
  localparam int A_STOP    = 1;
  localparam int A_COUNT   = 2;
  localparam int A_CLEAR   = 3;
  localparam int A_SHUT    = 4;
  localparam int A_CAP0    = 8;
  localparam int A_EVT0    = 16;
  localparam int A_SHORT   = 24;
  localparam int A_IENSET  = 25;
  localparam int A_IENCLR  = 26;
  localparam int A_MODE    = 27;
  localparam int A_WIDTH   = 28;
  localparam int A_PRESC   = 29;
  localparam int A_ERR     = 30;
  localparam int A_CC0     = 32;

  localparam int SC_STOP_LSB = 8;
  localparam int IEN_LSB     = 16;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNTER = 1'b1} mode_e;

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_FFFF;
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ct_prescaler.sv
`timescale 1ns/1ps
module ct_prescaler #(
  parameter int PW   = 4,
  parameter int PMAX = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ref_tick,
  input  logic [PW-1:0] presc,
  output logic          tick_en
);
  localparam int DIVW = PMAX + 1;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] limit;

  assign limit   = ~({DIVW{1'b1}} << presc);
  assign tick_en = run && ref_tick && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
    end else if (ref_tick) begin
      if (div_q >= limit) div_q <= '0;
      else                div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/ct_counter.sv
`timescale 1ns/1ps
module ct_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap_clr,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] adv_val
);
  assign adv_val = (cnt_q + 1'b1) & mask;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (adv)    cnt_q <= wrap_clr ? '0 : adv_val;
  end
endmodule

// File: rtl/ct_channel.sv
`timescale 1ns/1ps
module ct_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cc_wr,
  input  logic [DW-1:0] cc_wdata,
  input  logic          cap,
  input  logic [DW-1:0] cnt,
  input  logic          adv,
  input  logic [DW-1:0] adv_val,
  input  logic          evt_clr,
  output logic [DW-1:0] cc_q,
  output logic          evt_q,
  output logic          match
);
  assign match = adv && (adv_val == cc_q);

  always_ff @(posedge clk) begin
    if (rst)        cc_q <= '0;
    else if (cc_wr) cc_q <= cc_wdata;
    else if (cap)   cc_q <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)          evt_q <= 1'b0;
    else if (match)   evt_q <= 1'b1;
    else if (evt_clr) evt_q <= 1'b0;
  end
endmodule

// File: rtl/ct_timer.sv
`timescale 1ns/1ps
module ct_timer
  import ct_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int PW   = PRESC_W,
  parameter int PMAX = PRESC_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq
);
  // decode
  logic is_one, is_zero;
  logic t_start, t_stop, t_count, t_clear, t_shut;
  logic w_short, w_ienset, w_ienclr, w_mode, w_width, w_presc, w_err;
  logic [NCH-1:0] t_cap, w_cc, c_evt;

  assign is_one   = (bus_wdata == DW'(1));
  assign is_zero  = (bus_wdata == '0);
  assign t_start  = bus_wr && is_one && (bus_addr == AW'(A_START));
  assign t_stop   = bus_wr && is_one && (bus_addr == AW'(A_STOP));
  assign t_count  = bus_wr && is_one && (bus_addr == AW'(A_COUNT));
  assign t_clear  = bus_wr && is_one && (bus_addr == AW'(A_CLEAR));
  assign t_shut   = bus_wr && is_one && (bus_addr == AW'(A_SHUT));
  assign w_short  = bus_wr && (bus_addr == AW'(A_SHORT));
  assign w_ienset = bus_wr && (bus_addr == AW'(A_IENSET));
  assign w_ienclr = bus_wr && (bus_addr == AW'(A_IENCLR));
  assign w_mode   = bus_wr && (bus_addr == AW'(A_MODE));
  assign w_width  = bus_wr && (bus_addr == AW'(A_WIDTH));
  assign w_presc  = bus_wr && (bus_addr == AW'(A_PRESC));
  assign w_err    = bus_wr && (bus_addr == AW'(A_ERR));

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign t_cap[i] = bus_wr && is_one && (bus_addr == AW'(A_CAP0 + i));
    assign w_cc[i]  = bus_wr && (bus_addr == AW'(A_CC0 + i));
    assign c_evt[i] = bus_wr && is_zero && (bus_addr == AW'(A_EVT0 + i));
  end

  // configuration and control state
  mode_e          mode_q;
  logic [1:0]     width_q;
  logic [PW-1:0]  presc_q;
  logic [NCH-1:0] sc_clr_q, sc_stop_q, ien_q;
  logic           running_q, err_q;

  logic [DW-1:0]  mask;
  logic           tick_en, adv, wrap_clr, stop_hit;
  logic [DW-1:0]  cnt_q, adv_val;
  logic [DW-1:0]  cc_q [NCH];
  logic [NCH-1:0] evt_q, match_v;

  assign mask     = DW'(width_mask(width_q));
  assign wrap_clr = |(match_v & sc_clr_q);
  assign stop_hit = |(match_v & sc_stop_q);
  assign adv      = !t_clear && ((mode_q == MODE_TIMER) ? (tick_en && !t_stop && !t_shut)
                                                         : t_count);

  ct_prescaler #(.PW(PW), .PMAX(PMAX)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .run      (running_q && (mode_q == MODE_TIMER)),
    .ref_tick (ref_tick),
    .presc    (presc_q),
    .tick_en  (tick_en)
  );

  ct_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (t_clear),
    .adv      (adv),
    .wrap_clr (wrap_clr),
    .mask     (mask),
    .cnt_q    (cnt_q),
    .adv_val  (adv_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ct_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cc_wr    (w_cc[i]),
      .cc_wdata (bus_wdata & mask),
      .cap      (t_cap[i]),
      .cnt      (cnt_q),
      .adv      (adv),
      .adv_val  (adv_val),
      .evt_clr  (c_evt[i]),
      .cc_q     (cc_q[i]),
      .evt_q    (evt_q[i]),
      .match    (match_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_TIMER;
      width_q   <= 2'd0;
      presc_q   <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      ien_q     <= '0;
      running_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (w_mode)   mode_q  <= mode_e'(bus_wdata[0]);
      if (w_width)  width_q <= bus_wdata[1:0];
      if (w_presc)  presc_q <= (bus_wdata[PW-1:0] > PW'(PMAX)) ? PW'(PMAX) : bus_wdata[PW-1:0];
      if (w_short) begin
        sc_clr_q  <= bus_wdata[NCH-1:0];
        sc_stop_q <= bus_wdata[SC_STOP_LSB +: NCH];
      end
      if (w_ienset)      ien_q <= ien_q | bus_wdata[IEN_LSB +: NCH];
      else if (w_ienclr) ien_q <= ien_q & ~bus_wdata[IEN_LSB +: NCH];

      if (t_stop || t_shut || stop_hit)         running_q <= 1'b0;
      else if (t_start && mode_q == MODE_TIMER) running_q <= 1'b1;

      if (w_err && bus_wdata[0])
        err_q <= 1'b0;
      else if ((w_width || w_presc) && running_q && mode_q == MODE_TIMER)
        err_q <= 1'b1;
    end
  end

  // read path
  logic [DW-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (bus_addr == AW'(A_SHORT))  rd_d = (DW'(sc_stop_q) << SC_STOP_LSB) | DW'(sc_clr_q);
    if (bus_addr == AW'(A_IENSET) || bus_addr == AW'(A_IENCLR))
                                   rd_d = DW'(ien_q) << IEN_LSB;
    if (bus_addr == AW'(A_MODE))   rd_d = DW'(mode_q);
    if (bus_addr == AW'(A_WIDTH))  rd_d = DW'(width_q);
    if (bus_addr == AW'(A_PRESC))  rd_d = DW'(presc_q);
    if (bus_addr == AW'(A_ERR))    rd_d = DW'(err_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(A_EVT0 + i)) rd_d = DW'(evt_q[i]);
      if (bus_addr == AW'(A_CC0 + i))  rd_d = cc_q[i];
    end
  end

  logic [DW-1:0] rdata_q;
  logic          rvalid_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_d;
      irq_q    <= |(evt_q & ien_q);
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq        = irq_q;
endmodule

// File: rtl/ct_timer_chk.sv
`timescale 1ns/1ps
module ct_timer_chk
  import ct_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           bus_rvalid,
  input logic           irq,
  input logic [DW-1:0]  cnt_q,
  input logic [NCH-1:0] evt_q,
  input logic [NCH-1:0] ien_q,
  input logic           running_q,
  input logic           mode_q
);
  logic evt_wr, cnt_wr, clr_task, halt_task;
  assign evt_wr    = bus_wr && (bus_addr >= AW'(A_EVT0)) && (bus_addr < AW'(A_EVT0 + NCH));
  assign cnt_wr    = bus_wr && ((bus_addr == AW'(A_COUNT)) || (bus_addr == AW'(A_CLEAR)));
  assign clr_task  = bus_wr && (bus_addr == AW'(A_CLEAR)) && (bus_wdata == DW'(1));
  assign halt_task = bus_wr && ((bus_addr == AW'(A_STOP)) || (bus_addr == AW'(A_SHUT)))
                     && (bus_wdata == DW'(1));

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && evt_q == '0 && !irq));

  // R8
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_wr |=> ((~evt_q & $past(evt_q)) == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(evt_q & ien_q))));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !cnt_wr) |=> $stable(cnt_q));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_task |=> (cnt_q == '0));

  // R6
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt_task |=> !running_q);

  // R13
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

bind ct_timer ct_timer_chk #(.NCH(NCH), .DW(DW), .AW(AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .cnt_q      (cnt_q),
  .evt_q      (evt_q),
  .ien_q      (ien_q),
  .running_q  (running_q),
  .mode_q     (mode_q)
);

// File: tb/ct_timer_tb_top.sv
`timescale 1ns/1ps
module ct_timer_tb_top;
  import ct_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  always #10 clk = ~clk;

  ct_timer dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // monitor: pops expectations as read data appears
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cap_chk(input logic [31:0] e, input string tag);
    wr(A_CAP0, 32'd1);
    rd_chk(A_CC0, e, tag);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic count_n(input int n);
    for (int k = 0; k < n; k++) wr(A_COUNT, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd_chk(A_CC0, 0, "R1 cc0");
    rd_chk(A_EVT0, 0, "R1 evt0");
    rd_chk(A_IENSET, 0, "R1 enable");
    rd_chk(A_PRESC, 0, "R1 prescale");
    rd_chk(A_SHORT, 0, "R1 shortcuts");
    rd_chk(A_ERR, 0, "R1 error");
    irq_chk(1'b0, "R1");

    // R3 compare masking in every width
    wr(A_WIDTH, 0); wr(A_CC0 + 1, 32'hFFFF_FFFF); rd_chk(A_CC0 + 1, 32'h0000_FFFF, "R3 w16");
    wr(A_WIDTH, 1); wr(A_CC0 + 1, 32'hFFFF_FFFF); rd_chk(A_CC0 + 1, 32'h0000_00FF, "R3 w8");
    wr(A_WIDTH, 2); wr(A_CC0 + 1, 32'hFFFF_FFFF); rd_chk(A_CC0 + 1, 32'h00FF_FFFF, "R3 w24");
    wr(A_WIDTH, 3); wr(A_CC0 + 1, 32'hFFFF_FFFF); rd_chk(A_CC0 + 1, 32'hFFFF_FFFF, "R3 w32");

    // R5 R7 R12 counter mode
    wr(A_WIDTH, 1);
    wr(A_MODE, 1);
    wr(A_CLEAR, 1);
    count_n(5);
    cap_chk(5, "R7 capture after 5 counts R5");
    wr(A_START, 1); idle(10);
    cap_chk(5, "R5 start ignored in counter mode");
    wr(A_COUNT, 2);
    cap_chk(5, "R12 count with value 2");
    wr(A_CLEAR, 3);
    cap_chk(5, "R12 clear with value 3");

    // R2 8-bit wrap
    wr(A_CLEAR, 1);
    count_n(256);
    cap_chk(0, "R2 8-bit wrap");
    count_n(3);
    cap_chk(3, "R2 after wrap");

    // R8 sticky flag
    wr(A_CC0 + 2, 4);
    wr(A_EVT0 + 2, 0);
    wr(A_CLEAR, 1);
    count_n(3);
    rd_chk(A_EVT0 + 2, 0, "R8 before match");
    count_n(1);
    rd_chk(A_EVT0 + 2, 1, "R8 on match");
    count_n(1);
    wr(A_EVT0 + 2, 5);
    rd_chk(A_EVT0 + 2, 1, "R8 nonzero write keeps flag");
    wr(A_EVT0 + 2, 0);
    rd_chk(A_EVT0 + 2, 0, "R8 zero write clears");

    // R11 interrupt masking
    wr(A_CLEAR, 1);
    count_n(4);
    idle(2);
    irq_chk(1'b0, "R11 masked");
    wr(A_IENSET, 32'h0004_0000);
    idle(2);
    irq_chk(1'b1, "R11 enabled");
    rd_chk(A_IENSET, 32'h0004_0000, "R11 set readback");
    rd_chk(A_IENCLR, 32'h0004_0000, "R11 clear readback");
    wr(A_IENCLR, 32'h0004_0000);
    wr(A_IENSET, 32'h0002_0000);
    idle(2);
    irq_chk(1'b0, "R11 other channel enabled only");
    wr(A_IENCLR, 32'h0002_0000);

    // R9 clear shortcut
    wr(A_SHORT, 32'h0000_0008);
    wr(A_CC0 + 3, 6);
    wr(A_CLEAR, 1);
    count_n(6);
    cap_chk(0, "R9 cleared on match");
    rd_chk(A_EVT0 + 3, 1, "R9 flag on cleared match");
    count_n(2);
    cap_chk(2, "R9 continues from zero");

    // R10 stop shortcut, timer mode, prescale 0
    wr(A_SHORT, 32'h0000_0800);
    wr(A_CC0 + 3, 10);
    wr(A_MODE, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(30);
    cap_chk(10, "R10 halted at compare value");
    wr(A_SHORT, 0);

    // R4 prescale 2, R5 count ignored in timer mode
    wr(A_PRESC, 2);
    rd_chk(A_PRESC, 2, "R4 prescale readback");
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(20);
    wr(A_STOP, 1);
    cap_chk(5, "R4 20 strobes at prescale 2");
    wr(A_COUNT, 1);
    cap_chk(5, "R5 count ignored in timer mode");
    wr(A_PRESC, 15);
    rd_chk(A_PRESC, 9, "R4 prescale limited to 9");

    // R6 shutdown and clear
    wr(A_PRESC, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(7);
    wr(A_SHUT, 1);
    idle(5);
    cap_chk(7, "R6 shutdown halts");
    wr(A_CLEAR, 1);
    cap_chk(0, "R6 clear");

    // R14 error bit
    wr(A_START, 1);
    wr(A_PRESC, 0);
    wr(A_STOP, 1);
    rd_chk(A_ERR, 1, "R14 set by change while running");
    wr(A_ERR, 1);
    rd_chk(A_ERR, 0, "R14 cleared");

    // R13 unmapped index
    rd_chk(63, 0, "R13 unmapped read");
    wr(63, 32'h0000_0001);
    rd_chk(A_CC0 + 3, 10, "R13 unmapped write ignored");

    // R2 16-bit wrap in timer mode
    wr(A_WIDTH, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(65539);
    wr(A_STOP, 1);
    cap_chk(3, "R2 16-bit wrap");

    idle(4);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R13 missing read data actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule